// File: doc/BRIEF.md
# Interrupt Acknowledge and Nested Completion Tracker

This block is the per-CPU bookkeeping behind an interrupt controller's CPU interface. When the processor reads the acknowledge port, the tracker decides whether the highest-pending source offered by the priority selector may preempt the interrupt already being serviced. If it may, that source becomes the running interrupt, its priority becomes the running priority, and the tracker asks the pending logic to clear the source's pending state. Otherwise it answers with the spurious ID 1023 and changes nothing.

Each accepted interrupt records which interrupt it preempted, so every source carries one link to its predecessor. An end-of-interrupt write for the running interrupt pops back to its predecessor and reloads that predecessor's current priority. An end-of-interrupt for an interrupt further down the nesting is handled by a small walker. It follows the links one per cycle from the running interrupt and unlinks the retired entry, leaving the running interrupt untouched. A level-sensitive source that is still asserted when it is retired is handed back to the pending logic as a re-pend request.

Top module: `ackt_tracker`

## Requirements
- R1: An accepted acknowledge (ack_req high while busy is low) raises ack_valid for one cycle on the next clock edge. It returns ack_id 1023 and leaves the running state unchanged when hp_id is 1023, is not below NSRC, or has a priority not strictly below run_prio.
- R2: A successful acknowledge returns hp_id on ack_id and, on the same edge, sets run_id to hp_id and run_prio to that source's 8-bit priority with bit 8 clear.
- R3: A successful acknowledge pulses clr_valid with clr_id equal to the acknowledged ID. clr_all is 1 (clear for every CPU) when the source's src_one_to_n bit is 1, and 0 (this CPU only) otherwise.
- R4: After reset and whenever nothing is running, run_id is 1023 and run_prio is 9'h100.
- R5: An end-of-interrupt whose ID is NSRC or more (including 1023), or that arrives while run_id is 1023, changes no state and raises no re-pend.
- R6: An accepted end-of-interrupt for a source whose src_edge bit is 0 (level-sensitive), whose src_en, src_level and src_tgt bits are 1, pulses rep_valid with rep_id equal to that ID on the next edge.
- R7: An end-of-interrupt for run_id restores the interrupt it preempted as run_id, with run_prio taken from that source's current priority (9'h100 if it is 1023).
- R8: An end-of-interrupt for another valid ID raises busy from the next edge. The walker examines one link per cycle, starting at run_id, and removes the ID from the chain. run_id and run_prio do not change, and a later completion of the running interrupt skips the removed ID.
- R9: While busy is high, ack_req and eoi_req are ignored: no ack_valid, no state change.
- R10: When ack_req and eoi_req are accepted in the same cycle, the end-of-interrupt is served and the acknowledge returns 1023.
- R11: An end-of-interrupt for an ID absent from the chain ends the walk at the chain's end (link 1023) and leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_req | input | 1 | Acknowledge read strobe |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| eoi_id | input | 10 | ID written with the end-of-interrupt |
| hp_id | input | 10 | Highest-pending ID from the selector (1023 = none) |
| src_prio | input | NSRC*8 | Per-source priority, lower value is more urgent |
| src_edge | input | NSRC | 1 = edge-triggered, 0 = level-sensitive |
| src_one_to_n | input | NSRC | 1 = acknowledge clears pending for all CPUs |
| src_level | input | NSRC | Current input line level per source |
| src_en | input | NSRC | Source enable |
| src_tgt | input | NSRC | Source targets this CPU |
| busy | output | 1 | Chain walk in progress; strobes are ignored |
| ack_valid | output | 1 | Acknowledge answer valid |
| ack_id | output | 10 | Acknowledged ID or 1023 |
| run_id | output | 10 | Running interrupt ID (1023 = none) |
| run_prio | output | 9 | Running priority (9'h100 = none) |
| clr_valid | output | 1 | Pending-clear request |
| clr_id | output | 10 | ID whose pending state is cleared |
| clr_all | output | 1 | Clear for all CPUs (1) or this CPU only (0) |
| rep_valid | output | 1 | Re-pend request for a still-asserted level source |
| rep_id | output | 10 | ID to set pending again |

## Verification
The bench builds the tracker with NSRC set to 40. This leaves a wide band of out-of-range end-of-interrupt IDs (40 to 1022) next to 1023, and it keeps the walker's step limit short enough to reach. The small source count lets random traffic build nesting chains several levels deep, with splices in the middle of the chain and retirements of absent IDs. A behavioural model compares every output on every cycle, including the exact number of busy cycles.

// File: rtl/ackt_pkg.sv
package ackt_pkg;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;
    localparam int RP_W   = PRIO_W + 1;
    localparam logic [ID_W-1:0] NO_IRQ    = 10'd1023;
    localparam logic [RP_W-1:0] IDLE_PRIO = 9'h100;

    typedef logic [ID_W-1:0] irq_id_t;
    typedef logic [RP_W-1:0] run_prio_t;

    typedef enum logic {WK_IDLE, WK_STEP} walk_state_e;

    typedef struct packed {
        logic              hit;
        logic [PRIO_W-1:0] prio;
        logic              edge_trig;
        logic              one_to_n;
        logic              level;
        logic              enabled;
        logic              tgt_hit;
    } src_attr_t;

    function automatic run_prio_t prio_of(src_attr_t a);
        return a.hit ? {1'b0, a.prio} : IDLE_PRIO;
    endfunction

    function automatic logic still_raised(src_attr_t a);
        return a.hit && !a.edge_trig && a.enabled && a.level && a.tgt_hit;
    endfunction
endpackage

// File: rtl/ackt_src_lookup.sv
module ackt_src_lookup
    import ackt_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic [ID_W-1:0]              id,
    input  logic [NSRC-1:0][PRIO_W-1:0]  prio_v,
    input  logic [NSRC-1:0]              edge_v,
    input  logic [NSRC-1:0]              model_v,
    input  logic [NSRC-1:0]              level_v,
    input  logic [NSRC-1:0]              en_v,
    input  logic [NSRC-1:0]              tgt_v,
    output src_attr_t                    attr
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [IDX_W-1:0] idx;
    assign idx = id[IDX_W-1:0];

    always_comb begin
        attr = '0;
        if (id < ID_W'(NSRC)) begin
            attr.hit       = 1'b1;
            attr.prio      = prio_v[idx];
            attr.edge_trig = edge_v[idx];
            attr.one_to_n  = model_v[idx];
            attr.level     = level_v[idx];
            attr.enabled   = en_v[idx];
            attr.tgt_hit   = tgt_v[idx];
        end
    end
endmodule

// File: rtl/ackt_link_store.sv
module ackt_link_store
    import ackt_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  irq_id_t         rd0_idx,
    output irq_id_t         rd0_data,
    input  irq_id_t         rd1_idx,
    output irq_id_t         rd1_data,
    input  logic            wr_en,
    input  irq_id_t         wr_idx,
    input  irq_id_t         wr_data
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    irq_id_t links [NSRC];

    always_comb begin
        rd0_data = NO_IRQ;
        rd1_data = NO_IRQ;
        if (rd0_idx < ID_W'(NSRC)) rd0_data = links[rd0_idx[IDX_W-1:0]];
        if (rd1_idx < ID_W'(NSRC)) rd1_data = links[rd1_idx[IDX_W-1:0]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSRC; i++) links[i] <= NO_IRQ;
        end else if (wr_en && (wr_idx < ID_W'(NSRC))) begin
            links[wr_idx[IDX_W-1:0]] <= wr_data;
        end
    end
endmodule

// File: rtl/ackt_walk.sv
module ackt_walk
    import ackt_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  irq_id_t start_cur,
    input  irq_id_t start_tgt,
    input  irq_id_t link_of_cur,
    output irq_id_t cur,
    output irq_id_t tgt,
    output logic    busy,
    output logic    splice_we
);
    localparam int CW = $clog2(NSRC + 1);
    localparam logic [CW-1:0] MAX_STEP = CW'(NSRC - 1);

    walk_state_e    state;
    logic [CW-1:0]  steps;
    logic           at_end;
    logic           found;

    assign busy      = (state == WK_STEP);
    assign at_end    = (link_of_cur == NO_IRQ);
    assign found     = !at_end && (link_of_cur == tgt);
    assign splice_we = busy && found;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WK_IDLE;
            cur   <= NO_IRQ;
            tgt   <= NO_IRQ;
            steps <= '0;
        end else begin
            case (state)
                WK_IDLE: if (start) begin
                    state <= WK_STEP;
                    cur   <= start_cur;
                    tgt   <= start_tgt;
                    steps <= '0;
                end
                WK_STEP: begin
                    if (at_end || found || steps == MAX_STEP) begin
                        state <= WK_IDLE;
                    end else begin
                        cur   <= link_of_cur;
                        steps <= steps + 1'b1;
                    end
                end
                default: state <= WK_IDLE;
            endcase
        end
    end

    // R8
    walk_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> steps <= MAX_STEP);
    // R8
    walk_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
endmodule

// File: rtl/ackt_tracker.sv
module ackt_tracker
    import ackt_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ack_req,
    input  logic                      eoi_req,
    input  logic [9:0]                eoi_id,
    input  logic [9:0]                hp_id,
    input  logic [NSRC*8-1:0]         src_prio,
    input  logic [NSRC-1:0]           src_edge,
    input  logic [NSRC-1:0]           src_one_to_n,
    input  logic [NSRC-1:0]           src_level,
    input  logic [NSRC-1:0]           src_en,
    input  logic [NSRC-1:0]           src_tgt,
    output logic                      busy,
    output logic                      ack_valid,
    output logic [9:0]                ack_id,
    output logic [9:0]                run_id,
    output logic [8:0]                run_prio,
    output logic                      clr_valid,
    output logic [9:0]                clr_id,
    output logic                      clr_all,
    output logic                      rep_valid,
    output logic [9:0]                rep_id
);
    logic [NSRC-1:0][PRIO_W-1:0] prio_arr;
    assign prio_arr = src_prio;

    src_attr_t hp_attr, eoi_attr, pred_attr;
    irq_id_t   link_rd0, link_rd1, rd0_idx;
    irq_id_t   walk_cur, walk_tgt;
    logic      walk_busy, splice_we;
    logic      link_we;
    irq_id_t   link_widx, link_wdata;

    logic ack_take, eoi_take, eoi_ok, ack_good, walk_start;

    ackt_src_lookup #(.NSRC(NSRC)) u_hp_lu (
        .id(hp_id), .prio_v(prio_arr), .edge_v(src_edge), .model_v(src_one_to_n),
        .level_v(src_level), .en_v(src_en), .tgt_v(src_tgt), .attr(hp_attr));
    ackt_src_lookup #(.NSRC(NSRC)) u_eoi_lu (
        .id(eoi_id), .prio_v(prio_arr), .edge_v(src_edge), .model_v(src_one_to_n),
        .level_v(src_level), .en_v(src_en), .tgt_v(src_tgt), .attr(eoi_attr));
    ackt_src_lookup #(.NSRC(NSRC)) u_pred_lu (
        .id(link_rd0), .prio_v(prio_arr), .edge_v(src_edge), .model_v(src_one_to_n),
        .level_v(src_level), .en_v(src_en), .tgt_v(src_tgt), .attr(pred_attr));

    assign rd0_idx = walk_busy ? walk_cur : run_id;

    ackt_link_store #(.NSRC(NSRC)) u_links (
        .clk(clk), .rst(rst),
        .rd0_idx(rd0_idx), .rd0_data(link_rd0),
        .rd1_idx(walk_tgt), .rd1_data(link_rd1),
        .wr_en(link_we), .wr_idx(link_widx), .wr_data(link_wdata));

    ackt_walk #(.NSRC(NSRC)) u_walk (
        .clk(clk), .rst(rst), .start(walk_start),
        .start_cur(run_id), .start_tgt(eoi_id), .link_of_cur(link_rd0),
        .cur(walk_cur), .tgt(walk_tgt), .busy(walk_busy), .splice_we(splice_we));

    assign busy       = walk_busy;
    assign eoi_take   = eoi_req && !walk_busy;
    assign ack_take   = ack_req && !walk_busy;
    assign eoi_ok     = eoi_attr.hit && (run_id != NO_IRQ);
    assign ack_good   = ack_take && !eoi_req && hp_attr.hit && (prio_of(hp_attr) < run_prio);
    assign walk_start = eoi_take && eoi_ok && (eoi_id != run_id);

    always_comb begin
        link_we    = 1'b0;
        link_widx  = NO_IRQ;
        link_wdata = NO_IRQ;
        if (splice_we) begin
            link_we    = 1'b1;
            link_widx  = walk_cur;
            link_wdata = link_rd1;
        end else if (ack_good) begin
            link_we    = 1'b1;
            link_widx  = hp_id;
            link_wdata = run_id;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_id    <= NO_IRQ;
            run_prio  <= IDLE_PRIO;
            ack_valid <= 1'b0;
            ack_id    <= NO_IRQ;
            clr_valid <= 1'b0;
            clr_id    <= NO_IRQ;
            clr_all   <= 1'b0;
            rep_valid <= 1'b0;
            rep_id    <= NO_IRQ;
        end else begin
            ack_valid <= 1'b0;
            clr_valid <= 1'b0;
            rep_valid <= 1'b0;
            if (eoi_take && eoi_ok) begin
                if (still_raised(eoi_attr)) begin
                    rep_valid <= 1'b1;
                    rep_id    <= eoi_id;
                end
                if (eoi_id == run_id) begin
                    run_id   <= link_rd0;
                    run_prio <= prio_of(pred_attr);
                end
            end
            if (ack_take) begin
                ack_valid <= 1'b1;
                ack_id    <= ack_good ? hp_id : NO_IRQ;
                if (ack_good) begin
                    run_id    <= hp_id;
                    run_prio  <= prio_of(hp_attr);
                    clr_valid <= 1'b1;
                    clr_id    <= hp_id;
                    clr_all   <= hp_attr.one_to_n;
                end
            end
        end
    end

    // R4
    idle_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (run_id == NO_IRQ) == (run_prio == IDLE_PRIO));
    // R2
    ack_runs_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_id != NO_IRQ) |-> (run_id == ack_id && run_prio < $past(run_prio)));
    // R9
    busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!ack_valid && !rep_valid));
    // R8
    walk_keeps_run_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(run_id) && $stable(run_prio)));
    // R5
    eoi_range_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_req && !busy && eoi_id >= 10'(NSRC) && !ack_req) |=> ($stable(run_id) && !rep_valid));
    // R3
    clr_pairs_ack_chk: assert property (@(posedge clk) disable iff (rst)
        clr_valid |-> (ack_valid && clr_id == ack_id));
endmodule

// File: tb/sim_ackt_tracker.sv
`timescale 1ns/1ps
module sim_ackt_tracker;
    localparam int NSRC = 40;
    localparam int NONE = 1023;

    logic clk = 0;
    logic rst = 1;
    always #2 clk = ~clk;

    logic ack_req = 0, eoi_req = 0;
    logic [9:0] eoi_id = 0, hp_id = 10'd1023;
    logic [NSRC-1:0][7:0] b_prio;
    logic [NSRC-1:0] b_edge, b_model, b_lvl, b_en, b_tgt;

    logic busy, ack_valid, clr_valid, clr_all, rep_valid;
    logic [9:0] ack_id, run_id, clr_id, rep_id;
    logic [8:0] run_prio;

    ackt_tracker #(.NSRC(NSRC)) u0 (
        .clk(clk), .rst(rst), .ack_req(ack_req), .eoi_req(eoi_req), .eoi_id(eoi_id),
        .hp_id(hp_id), .src_prio(b_prio), .src_edge(b_edge), .src_one_to_n(b_model),
        .src_level(b_lvl), .src_en(b_en), .src_tgt(b_tgt), .busy(busy),
        .ack_valid(ack_valid), .ack_id(ack_id), .run_id(run_id), .run_prio(run_prio),
        .clr_valid(clr_valid), .clr_id(clr_id), .clr_all(clr_all),
        .rep_valid(rep_valid), .rep_id(rep_id));

    int total = 0, bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_run, m_prio, m_link[NSRC];
    bit m_busy;
    int w_cur, w_tgt, w_steps;
    bit e_ackv, e_clrv, e_clrall, e_repv;
    int e_ackid, e_clrid, e_repid;

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lnk(int i);
        return (i >= 0 && i < NSRC) ? m_link[i] : NONE;
    endfunction

    task automatic model_step(bit a, bit e, int eid, int hp);
        e_ackv = 0; e_clrv = 0; e_repv = 0;
        if (m_busy) begin
            int nxt = lnk(w_cur);
            if (nxt == NONE) m_busy = 0;
            else if (nxt == w_tgt) begin m_link[w_cur] = lnk(w_tgt); m_busy = 0; end
            else if (w_steps == NSRC - 1) m_busy = 0;
            else begin w_cur = nxt; w_steps++; end
            return;
        end
        if (e && eid < NSRC && m_run != NONE) begin
            if (!b_edge[eid] && b_en[eid] && b_lvl[eid] && b_tgt[eid]) begin
                e_repv = 1; e_repid = eid;
            end
            if (eid == m_run) begin
                m_run  = lnk(m_run);
                m_prio = (m_run == NONE) ? 256 : int'(b_prio[m_run]);
            end else begin
                m_busy = 1; w_cur = m_run; w_tgt = eid; w_steps = 0;
            end
        end
        if (a) begin
            e_ackv = 1; e_ackid = NONE;
            if (!e && hp < NSRC && int'(b_prio[hp]) < m_prio) begin
                e_ackid = hp;
                m_link[hp] = m_run;
                m_run = hp; m_prio = b_prio[hp];
                e_clrv = 1; e_clrid = hp; e_clrall = b_model[hp];
            end
        end
    endtask

    task automatic compare_all();
        chk(ack_valid == e_ackv, "R1 ack_valid", ack_valid, e_ackv);
        if (e_ackv) chk(ack_id == e_ackid, "R2 ack_id", ack_id, e_ackid);
        chk(run_id == m_run, "R2 run_id", run_id, m_run);
        chk(run_prio == m_prio, "R7 run_prio", run_prio, m_prio);
        chk(clr_valid == e_clrv, "R3 clr_valid", clr_valid, e_clrv);
        if (e_clrv) begin
            chk(clr_id == e_clrid, "R3 clr_id", clr_id, e_clrid);
            chk(clr_all == e_clrall, "R3 clr_all", clr_all, e_clrall);
        end
        chk(rep_valid == e_repv, "R6 rep_valid", rep_valid, e_repv);
        if (e_repv) chk(rep_id == e_repid, "R6 rep_id", rep_id, e_repid);
        chk(busy == m_busy, "R8 busy", busy, m_busy);
    endtask

    task automatic step(bit a, bit e, int eid, int hp);
        ack_req = a; eoi_req = e; eoi_id = 10'(eid); hp_id = 10'(hp);
        model_step(a, e, eid, hp);
        @(posedge clk); #1;
        compare_all();
        ack_req = 0; eoi_req = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NSRC; i++) begin
            b_prio[i] = 8'hFF; b_edge[i] = 1; b_model[i] = 0;
            b_lvl[i] = 0; b_en[i] = 1; b_tgt[i] = 1; m_link[i] = NONE;
        end
        m_run = NONE; m_prio = 256; m_busy = 0;
        e_ackv = 0; e_clrv = 0; e_repv = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        chk(run_id == 10'd1023, "R4 reset run_id", run_id, NONE);
        chk(run_prio == 9'h100, "R4 reset run_prio", run_prio, 256);
        chk(busy == 0 && ack_valid == 0, "R4 reset strobes", busy, 0);

        step(1, 0, 0, NONE);
        chk(ack_valid && ack_id == 10'd1023, "R1 no pending", ack_id, NONE);
        b_prio[5] = 8'h80;
        step(1, 0, 0, 5);
        chk(ack_id == 5 && run_prio == 9'h080, "R2 first ack", run_prio, 'h80);
        chk(clr_valid && clr_id == 5 && !clr_all, "R3 local clear", clr_all, 0);
        b_prio[7] = 8'h80;
        step(1, 0, 0, 7);
        chk(ack_id == 10'd1023 && run_id == 5, "R1 equal priority", ack_id, NONE);
        b_prio[9] = 8'h40; b_model[9] = 1;
        step(1, 0, 0, 9);
        chk(clr_all == 1, "R3 one-to-n clear", clr_all, 1);
        b_prio[12] = 8'h10;
        step(1, 0, 0, 12);
        chk(run_id == 12, "R2 nested", run_id, 12);
        step(0, 1, 45, NONE);
        chk(run_id == 12, "R5 out of range", run_id, 12);
        step(0, 1, NONE, NONE);
        chk(run_id == 12, "R5 spurious id", run_id, 12);
        step(0, 1, 9, NONE);
        chk(busy == 1 && run_id == 12, "R8 walk starts", busy, 1);
        b_prio[3] = 8'h00;
        step(1, 0, 0, 3);
        chk(ack_valid == 0 && busy == 0, "R9 stalled ack", ack_valid, 0);
        step(0, 1, 30, NONE);
        step(0, 0, 0, NONE);
        chk(busy == 1, "R11 second link", busy, 1);
        step(0, 0, 0, NONE);
        chk(busy == 0 && run_id == 12 && run_prio == 9'h010, "R11 absent id", run_id, 12);
        b_edge[12] = 0; b_lvl[12] = 1;
        step(0, 1, 12, NONE);
        chk(rep_valid && rep_id == 12, "R6 repend", rep_id, 12);
        chk(run_id == 5 && run_prio == 9'h080, "R7 restore skips spliced", run_id, 5);
        step(1, 1, 5, 3);
        chk(ack_valid && ack_id == 10'd1023 && run_id == 10'd1023, "R10 simultaneous", ack_id, NONE);
        chk(run_prio == 9'h100, "R4 idle again", run_prio, 256);
        b_edge[5] = 0; b_lvl[5] = 1;
        step(0, 1, 5, NONE);
        chk(rep_valid == 0 && run_id == 10'd1023, "R5 eoi while idle", rep_valid, 0);

        for (int i = 0; i < NSRC; i++) begin
            b_prio[i] = 8'($urandom_range(0, 255));
            b_edge[i] = 1'($urandom_range(0, 1));
            b_model[i] = 1'($urandom_range(0, 1));
            b_lvl[i] = 1'($urandom_range(0, 1));
            b_en[i] = 1'($urandom_range(0, 1));
            b_tgt[i] = 1'($urandom_range(0, 1));
        end
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 9);
            int hp = ($urandom_range(0, 7) == 0) ? NONE : $urandom_range(0, NSRC - 1);
            int ei = ($urandom_range(0, 9) == 0) ? $urandom_range(NSRC, NONE)
                   : (($urandom_range(0, 1) == 1 && m_run != NONE) ? m_run : $urandom_range(0, NSRC - 1));
            if (n % 200 == 0) b_prio[$urandom_range(0, NSRC - 1)] = 8'($urandom_range(0, 255));
            step(r < 5, r >= 4 && r < 8, ei, hp);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule